// File: doc/BRIEF.md
# Fractional-Ratio 16x Baud Tick Generator

This block turns a free-running system clock into a train of one-cycle enable pulses at sixteen times a serial bit rate. Two dividers sit in series. The first is a small prescaler with a ratio of 1, 3, 4 or 5. The second is a divisor chosen from a fixed menu, and that menu holds three non-integer ratios. Each non-integer ratio is built by cycling through three integer period lengths whose sum equals the numerator. No derived clock is produced: the prescaler emits an enable that steps the divisor counter, and the divisor emits the 16x tick. All downstream logic stays on the system clock.

One 8-bit configuration byte is loaded through a write strobe. It selects the prescaler ratio, the divisor and the clock-out source. The clock-out enable either stays high on every cycle, which mirrors the raw input clock, or follows the 16x tick. Each load restarts both counters and the fractional phase from zero. The first tick after a load therefore comes exactly one full period after the write edge, and no short or stretched period can occur.

There is no data stream through this block: the write strobe and both outputs are plain control pins with no back-pressure.

Top module: `frac_baud_gen`

## Requirements
- R1: Byte bits [1:0] pick the prescale ratio: 00 gives 1, 01 gives 3, 10 gives 4, 11 gives 5. The tick period is the prescale ratio times the divisor period.
- R2: Byte bits [6:2] pick an integer divisor: 00000=2, 00001=4, 00011=8, 00101=16, 00111=22, 01000=32, 01001=64, 01010=128, 01011=192, 01100=256, 01101=288, 01110=352, 01111=512, 10000=768.
- R3: The fractional codes repeat a three-period cycle, starting with the first period after a load. Code 00010 (16/3) gives 5,5,6. Code 00100 (32/3) gives 11,11,10. Code 00110 (58/3) gives 19,19,20. Each length is in prescaled steps.
- R4: Divisor code 11111 bypasses the divisor, so every prescaler step is a tick. With prescale 1, the tick stays high on every cycle.
- R5: Divisor codes 10001 to 11110 behave as divide by 2.
- R6: When the tick period exceeds one cycle, `tick16` is high for exactly one system clock per period.
- R7: Byte bit 7 selects the clock-out source. With bit 7 at 0, `clk_out_en` is 1 on every cycle. With bit 7 at 1, `clk_out_en` equals `tick16` on every cycle.
- R8: A write (`cfg_wr` high at a rising edge) clears both counters and the fractional phase, and also clears `tick16`. For a period sequence N1,N2,..., the first tick appears N1 cycles after the write edge and the next one N2 cycles after that.
- R9: Reset loads byte 0x00 and holds `tick16` low. After reset is released, ticks come every 2 cycles, with the first one on the second rising edge.
- R10: Byte 0x86 (prescale 4, divisor 4, clock-out follows the tick) gives a period of 16 cycles. With a 2.4576 MHz clock this is 153.6 kHz, which is 16 x 9600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Strobe that loads `cfg_data` and restarts the dividers |
| cfg_data | input | 8 | Configuration byte: [1:0] prescale, [6:2] divisor, [7] clock-out source |
| tick16 | output | 1 | One-cycle enable pulse at 16x the bit rate |
| clk_out_en | output | 1 | Clock-out enable, mirroring either the input clock or the tick |

## Verification
The fractional codes are the main target. The bench measures three consecutive periods after each load, so a design that dithered in the wrong order would show up, for example 6,5,5 instead of 5,5,6. So would one that kept the fractional phase across a reload, or forgot the prescaler when counting the longer period. The table also covers the unused codes, the bypass code with ratios 1 and 3, and the 768 x 5 extreme. A design that decoded these codes wrongly, or truncated its counter, would give wrong period lengths. Directed tests rewrite the byte in the middle of a period and in the middle of a fractional cycle, and they check the post-reset cadence and the pulse width. A design that did not restart on a write would give a short or stretched first period. A design whose pulse was too wide would leave the output high on the following cycle.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  localparam int PRE_W = 3;   // holds prescale ratios up to 5
  localparam int DIV_W = 10;  // holds divisor lengths up to 768
  localparam int PH_W  = 2;   // three-step fractional phase

  localparam logic [4:0] CODE_BYPASS = 5'h1F;

  typedef struct packed {
    logic       co_sel;
    logic [4:0] div_code;
    logic [1:0] pre_code;
  } fbg_cfg_t;

  function automatic logic [PRE_W-1:0] pre_ratio(input logic [1:0] code);
    logic [PRE_W-1:0] r;
    case (code)
      2'd0:    r = PRE_W'(1);
      2'd1:    r = PRE_W'(3);
      2'd2:    r = PRE_W'(4);
      default: r = PRE_W'(5);
    endcase
    return r;
  endfunction

  // Length of the current divisor period in prescaled steps; phase 2 is the odd one out
  function automatic logic [DIV_W-1:0] div_len(input logic [4:0] code, input logic [PH_W-1:0] ph);
    logic [DIV_W-1:0] n;
    logic             last;
    last = (ph == PH_W'(2));
    case (code)
      5'h00:   n = DIV_W'(2);
      5'h01:   n = DIV_W'(4);
      5'h02:   n = last ? DIV_W'(6)  : DIV_W'(5);
      5'h03:   n = DIV_W'(8);
      5'h04:   n = last ? DIV_W'(10) : DIV_W'(11);
      5'h05:   n = DIV_W'(16);
      5'h06:   n = last ? DIV_W'(20) : DIV_W'(19);
      5'h07:   n = DIV_W'(22);
      5'h08:   n = DIV_W'(32);
      5'h09:   n = DIV_W'(64);
      5'h0A:   n = DIV_W'(128);
      5'h0B:   n = DIV_W'(192);
      5'h0C:   n = DIV_W'(256);
      5'h0D:   n = DIV_W'(288);
      5'h0E:   n = DIV_W'(352);
      5'h0F:   n = DIV_W'(512);
      5'h10:   n = DIV_W'(768);
      5'h1F:   n = DIV_W'(1);
      default: n = DIV_W'(2);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] ratio,
  output logic             step
);

  logic [CNT_W-1:0] cnt;

  assign step = (cnt == ratio - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end

  // the count never reaches the selected ratio
  assert_pre_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);

endmodule

// File: rtl/fbg_divisor.sv
module fbg_divisor
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       step,
  input  logic [4:0] code,
  output logic       tick
);

  logic [DIV_W-1:0] dcnt;
  logic [PH_W-1:0]  ph;
  logic [DIV_W-1:0] len;
  logic             byp;
  logic             hit;
  logic             tick_q;

  assign len  = div_len(code, ph);
  assign byp  = (code == CODE_BYPASS);
  assign hit  = step && (byp || (dcnt == len - DIV_W'(1)));
  assign tick = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt   <= '0;
      ph     <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      dcnt   <= '0;
      ph     <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= hit;
      if (hit) begin
        dcnt <= '0;
        ph   <= (ph == PH_W'(2)) ? '0 : ph + PH_W'(1);
      end else if (step) begin
        dcnt <= dcnt + DIV_W'(1);
      end
    end
  end

  assert_div_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !byp |-> dcnt < len);

  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph != PH_W'(3));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !byp && !restart) |=> !tick_q);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_data,
  output logic       tick16,
  output logic       clk_out_en
);

  fbg_cfg_t         cfg_q;
  logic             pre_step;
  logic [PRE_W-1:0] ratio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= fbg_cfg_t'(cfg_data);
  end

  assign ratio = pre_ratio(cfg_q.pre_code);

  fbg_prescaler #(.CNT_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .ratio   (ratio),
    .step    (pre_step)
  );

  fbg_divisor u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .step    (pre_step),
    .code    (cfg_q.div_code),
    .tick    (tick16)
  );

  assign clk_out_en = cfg_q.co_sel ? tick16 : 1'b1;

  // a load always leaves the tick low in the following cycle
  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !tick16);

  // whichever source is chosen, a tick is never masked on the clock-out enable
  assert_mirror_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |-> clk_out_en);

  // the tick only rises after a prescaler step in the previous cycle
  assert_tick_needs_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !pre_step) |=> !tick16);

endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       tick16;
  logic       clk_out_en;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .tick16(tick16), .clk_out_en(clk_out_en)
  );

  localparam int NV = 15;
  localparam logic [7:0] VCFG [NV] = '{8'h86, 8'h00, 8'h08, 8'h89, 8'h10, 8'h1B, 8'h7C, 8'hFD,
                                      8'h40, 8'h43, 8'h44, 8'h7A, 8'h3C, 8'h1F, 8'h2D};
  localparam int VN0 [NV] = '{16, 2, 5, 15, 11, 95,  1, 3, 768, 3840, 2, 8, 512, 110, 576};
  localparam int VN1 [NV] = '{16, 2, 5, 15, 11, 95,  1, 3, 768, 3840, 2, 8, 512, 110, 576};
  localparam int VN2 [NV] = '{16, 2, 6, 18, 10, 100, 1, 3, 768, 3840, 2, 8, 512, 110, 576};
  localparam string VTAG [NV] = '{"R10", "R2", "R3", "R1", "R3", "R3", "R4", "R4",
                                  "R2", "R1", "R5", "R5", "R2", "R1", "R2"};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] b);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_data = b;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Called just after the negedge that follows the start edge; measures three intervals
  task automatic run_periods(input int e0, input int e1, input int e2,
                             input logic [7:0] cfg, input string tag);
    int exp [3];
    int last = 0;
    int got = 0;
    int k = 0;
    bit mir_bad = 0;
    exp = '{e0, e1, e2};
    while (got < 3 && k < 20000) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (cfg[7] ? (clk_out_en !== tick16) : (clk_out_en !== 1'b1)) mir_bad = 1;
      if (tick16 === 1'b1) begin
        check((k - last) == exp[got], tag, k - last, exp[got]);
        last = k;
        got++;
      end
    end
    check(got == 3, {tag, " pulses seen"}, got, 3);
    check(!mir_bad, "R7 clock-out mirror", int'(mir_bad), 0);
  endtask

  task automatic wait_tick();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (tick16 !== 1'b1 && k < 20000);
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check(tick16 === 1'b0, "R9 tick low in reset", int'(tick16), 0);
    check(clk_out_en === 1'b1, "R9 clock-out in reset", int'(clk_out_en), 1);
    rst_n = 1'b1;
    run_periods(2, 2, 2, 8'h00, "R9");

    // table of configurations, each loaded while the previous one runs (R8 restart)
    for (int i = 0; i < NV; i++) begin
      write_cfg(VCFG[i]);
      check(tick16 === 1'b0, "R8 tick cleared by write", int'(tick16), 0);
      run_periods(VN0[i], VN1[i], VN2[i], VCFG[i], VTAG[i]);
    end

    // R6: the cycle after a tick is low
    write_cfg(8'h86);
    wait_tick();
    @(negedge clk);
    check(tick16 === 1'b0, "R6 single-cycle pulse", int'(tick16), 0);

    // R8: rewrite in mid-period, the full period restarts
    repeat (6) @(negedge clk);
    write_cfg(8'h86);
    run_periods(16, 16, 16, 8'h86, "R8 mid-period reload");

    // R8: rewrite in mid fractional cycle, the phase restarts at the first length
    write_cfg(8'h08);
    wait_tick();
    write_cfg(8'h08);
    run_periods(5, 5, 6, 8'h08, "R8 phase restart");

    // R7: clock-out follows the tick with bit 7 set, and the period is unaffected
    write_cfg(8'h80);
    run_periods(2, 2, 2, 8'h80, "R7 period with mirror");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule